// File: doc/BRIEF.md
# Speculative Operand Queue Input Buffer

This block connects an external synchronous FIFO to a processor pipeline that uses queue words as instruction operands. It holds at most two words. It pulls words from the external FIFO on its own whenever a slot is free and the FIFO reports data. It gives the oldest unread word to an instruction that asks for it.

A word an instruction reads is not thrown away at once. It stays in the buffer, marked as consumed, until the reading instruction retires and a commit pulse frees it. If the pipeline kills its in-flight instructions, every consumed word returns to the unread state in its original order, so it can be read again. The external FIFO therefore never sees a pop that must be undone.

An instruction reads with a blocking request, which stalls while nothing is unread. Software can also test the empty indication first and do other work instead of stalling. When each read retires in the same cycle, the buffer delivers one operand per cycle.

Top module: `spec_inq_buf`

## Requirements
- R1: While `rst_n` is low, `fifo_pop_o` is 0 and `q_empty_o` is 1. In the first cycle after reset is released, `fifo_pop_o` stays 0 and the buffer holds nothing.
- R2: `fifo_pop_o` is never 1 in a cycle where `fifo_empty_i` is 1.
- R3: The external FIFO is show-ahead: `fifo_data_i` carries its head word whenever `fifo_empty_i` is 0. The word present in a cycle with `fifo_pop_o` high is stored at that clock edge. Stored words are delivered in the order they were popped.
- R4: In any cycle, `fifo_pop_o` is 1 exactly when both of these hold: the buffer held fewer than two words (unread plus consumed) at the previous edge, and `fifo_empty_i` is 0. The buffer never holds more than two words.
- R5: `rd_stall_o` is 1 exactly when `rd_req_i` is 1 and no unread word is held. A stalled request changes nothing.
- R6: `q_empty_o` is 1 exactly when no unread word is held. Watching it changes no state.
- R7: `rd_data_o` shows the oldest unread word. A request without kill, made while a word is unread, marks that word as consumed at the edge.
- R8: `commit_i` frees the oldest consumed word. A word read in the same cycle counts as consumed. A commit with no consumed word is ignored.
- R9: `kill_i` turns every consumed word back into an unread word in the original order, after any commit in the same cycle. A read request in a kill cycle is ignored.
- R10: With the external FIFO non-empty and `rd_req_i` and `commit_i` held high, one word is delivered every cycle without a stall, starting from the third cycle after an empty start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty_i | input | 1 | External FIFO has no data |
| fifo_data_i | input | DATA_W | External FIFO head word |
| fifo_pop_o | output | 1 | Pop the external FIFO head at this edge |
| rd_req_i | input | 1 | Instruction requests an operand (blocking) |
| rd_data_o | output | DATA_W | Oldest unread word |
| rd_stall_o | output | 1 | Request cannot be served this cycle |
| q_empty_o | output | 1 | No unread word (non-blocking query) |
| commit_i | input | 1 | Oldest reading instruction retires |
| kill_i | input | 1 | Pipeline flush; consumed words are restored |

## Verification
A software model of the slots and of the show-ahead external FIFO drives the bench. It is tried first with back-to-back read-and-retire traffic, which shows whether the buffer can keep full rate or loses cycles to its refill rule. Directed read, read, kill, re-read sequences check that order is kept on replay. Commits issued with nothing consumed, and reads issued during a kill, check that ignored events change nothing. Long random mixes of producer gaps, reads, commits and kills then check when the pop is issued, when stalls occur and which data is returned under pressure on both slots.

// File: rtl/sqb_pkg.sv
package sqb_pkg;

  // events resolved for one clock edge
  typedef struct packed {
    logic rd;    // a read consumes the oldest unread word
    logic cm;    // a retire frees the oldest consumed word
    logic kill;  // consumed words go back to unread
    logic fill;  // a word arrives from the external FIFO
  } sqb_ev_t;

endpackage

// File: rtl/sqb_ctrl.sv
module sqb_ctrl
  import sqb_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req_i,
  input  logic          commit_i,
  input  logic          kill_i,
  input  logic          fifo_empty_i,
  output logic          fifo_pop_o,
  output logic          rd_stall_o,
  output logic          q_empty_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o
);

  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] FULL = CW'(SLOTS);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  // head: oldest consumed (or oldest unread if none consumed)
  logic [PW-1:0] head_q, head_d, rd_q, rd_d, tail_q, tail_d;
  logic [CW-1:0] nspec_q, nspec_d, nvalid_q, nvalid_d;
  logic          room_q, room_d;
  logic [CW-1:0] spec_sum, spec_left, valid_left, occ_q;
  logic          avail;
  sqb_ev_t       ev;

  assign occ_q      = nspec_q + nvalid_q;
  assign avail      = (nvalid_q != '0);
  assign q_empty_o  = ~avail;
  assign rd_stall_o = rd_req_i & ~avail;
  assign fifo_pop_o = room_q & ~fifo_empty_i;
  assign wr_ptr_o   = tail_q;
  assign rd_ptr_o   = rd_q;

  always_comb begin
    ev.kill = kill_i;
    ev.fill = fifo_pop_o;
    ev.rd   = rd_req_i & avail & ~kill_i;
    spec_sum   = nspec_q + CW'(ev.rd);
    ev.cm      = commit_i & (spec_sum != '0);
    spec_left  = spec_sum - CW'(ev.cm);
    valid_left = nvalid_q - CW'(ev.rd) + CW'(ev.fill);
    head_d     = ev.cm ? bump(head_q) : head_q;
    tail_d     = ev.fill ? bump(tail_q) : tail_q;
    if (ev.kill) begin
      nspec_d  = '0;
      nvalid_d = valid_left + spec_left;
      rd_d     = head_d;
    end else begin
      nspec_d  = spec_left;
      nvalid_d = valid_left;
      rd_d     = ev.rd ? bump(rd_q) : rd_q;
    end
    room_d = (nspec_d + nvalid_d) < FULL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      rd_q     <= '0;
      tail_q   <= '0;
      nspec_q  <= '0;
      nvalid_q <= '0;
      room_q   <= 1'b0;
    end else begin
      head_q   <= head_d;
      rd_q     <= rd_d;
      tail_q   <= tail_d;
      nspec_q  <= nspec_d;
      nvalid_q <= nvalid_d;
      room_q   <= room_d;
    end
  end

  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL);

  assert_pop_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> (occ_q < FULL));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stall_o && !kill_i && !commit_i && !fifo_pop_o) |=>
      ($stable(nspec_q) && $stable(nvalid_q)));

  assert_read_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !q_empty_o && !kill_i && !commit_i) |=>
      (nspec_q == $past(nspec_q) + CW'(1)));

  assert_commit_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && nspec_q != '0 && !rd_req_i && !kill_i && !fifo_pop_o) |=>
      (occ_q == $past(occ_q) - CW'(1)));

  assert_kill_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (nspec_q == '0));

endmodule

// File: rtl/sqb_store.sv
module sqb_store #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 2,
  parameter int PW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [PW-1:0]     wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PW-1:0]     rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en_i && (wr_ptr_i == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_ptr_i];

endmodule

// File: rtl/spec_inq_buf.sv
module spec_inq_buf #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_stall_o,
  output logic              q_empty_o,
  input  logic              commit_i,
  input  logic              kill_i
);

  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [PW-1:0] wr_ptr, rd_ptr;

  sqb_ctrl #(.SLOTS(SLOTS), .PW(PW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_i     (rd_req_i),
    .commit_i     (commit_i),
    .kill_i       (kill_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_pop_o   (fifo_pop_o),
    .rd_stall_o   (rd_stall_o),
    .q_empty_o    (q_empty_o),
    .wr_ptr_o     (wr_ptr),
    .rd_ptr_o     (rd_ptr)
  );

  sqb_store #(.DATA_W(DATA_W), .SLOTS(SLOTS), .PW(PW)) u_store (
    .clk       (clk),
    .wr_en_i   (fifo_pop_o),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (fifo_data_i),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (rd_data_o)
  );

  assert_pop_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

endmodule

// File: tb/sim_spec_inq_buf.sv
module sim_spec_inq_buf;
  localparam int DW = 32;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, fifo_empty_i, fifo_pop_o, rd_req_i, rd_stall_o, q_empty_o, commit_i, kill_i;
  logic [DW-1:0] fifo_data_i, rd_data_o;

  spec_inq_buf #(.DATA_W(DW), .SLOTS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i),
    .fifo_pop_o(fifo_pop_o), .rd_req_i(rd_req_i), .rd_data_o(rd_data_o),
    .rd_stall_o(rd_stall_o), .q_empty_o(q_empty_o), .commit_i(commit_i), .kill_i(kill_i)
  );

  logic [DW-1:0] ext_q[$];
  logic [DW-1:0] held[$];   // oldest first; the first nspec are consumed
  int  nspec;
  bit  room_exp;
  int  n_vec, n_bad;
  bit  finished;
  logic [DW-1:0] last_data;
  bit  last_stall;

  function bit exp_empty();
    return (held.size() - nspec) == 0;
  endfunction

  function bit exp_pop();
    return room_exp && (ext_q.size() != 0);
  endfunction

  task chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // called at a falling edge; returns at the next falling edge
  task step(input bit rq, input bit cm, input bit kl);
    bit p, rf, cf;
    int sp;
    rd_req_i = rq; commit_i = cm; kill_i = kl;
    fifo_empty_i = (ext_q.size() == 0);
    fifo_data_i  = (ext_q.size() != 0) ? ext_q[0] : '0;
    #1;
    chk("R6", "q_empty", q_empty_o, exp_empty());
    chk("R5", "stall", rd_stall_o, rq && exp_empty());
    chk((ext_q.size() == 0) ? "R2" : "R4", "pop", fifo_pop_o, exp_pop());
    if (!exp_empty()) chk("R3 R7", "data", rd_data_o, held[nspec]);
    last_data  = rd_data_o;
    last_stall = rd_stall_o;
    p = exp_pop();
    @(posedge clk); #1;
    rf = rq && !exp_empty() && !kl;
    sp = nspec + int'(rf);
    cf = cm && (sp > 0);
    if (cf) begin void'(held.pop_front()); sp--; end
    nspec = kl ? 0 : sp;
    if (p) held.push_back(ext_q.pop_front());
    room_exp = held.size() < NS;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 40000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int stalls;
    logic [DW-1:0] wa, wb, wc;
    seed = $urandom(32'h5eed);
    n_vec = 0; n_bad = 0; finished = 0; nspec = 0; room_exp = 0;
    rst_n = 1'b0; rd_req_i = 0; commit_i = 0; kill_i = 0;
    fifo_empty_i = 1'b0; fifo_data_i = 32'h1234_5678;
    // R1: reset holds off pops even with external data present
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", "pop in reset", fifo_pop_o, 1'b0);
      chk("R1", "empty in reset", q_empty_o, 1'b1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0);                       // first cycle: no pop (R1)

    // R10: full rate with read and retire every cycle
    for (int i = 0; i < 24; i++) ext_q.push_back($urandom);
    stalls = 0;
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 0);
      if (i >= 2 && last_stall) stalls++;
    end
    chk("R10", "stalls at full rate", stalls, 0);
    for (int i = 0; i < 40 && (held.size() != 0 || ext_q.size() != 0); i++) step(1, 1, 0);

    // R9: read two, kill, re-read in order; read during kill ignored
    wa = 32'hA0A0_0001; wb = 32'hB0B0_0002; wc = 32'hC0C0_0003;
    ext_q.push_back(wa); ext_q.push_back(wb);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 0); chk("R7", "first read", last_data, wa);
    step(1, 0, 0); chk("R7", "second read", last_data, wb);
    step(0, 0, 0); chk("R7", "empty after two reads", q_empty_o, 1'b1);
    step(1, 0, 1);                       // kill, read ignored
    step(1, 1, 0); chk("R9", "replay first", last_data, wa);
    step(1, 1, 0); chk("R9", "replay second", last_data, wb);

    // R8: commits with nothing consumed are ignored
    step(0, 1, 0);
    ext_q.push_back(wc);
    step(0, 0, 0); step(0, 0, 0);
    step(0, 1, 0); chk("R8", "word kept after stray commit", q_empty_o, 1'b0);
    step(1, 0, 0); chk("R8", "word after stray commit", last_data, wc);
    step(0, 1, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 2) == 0 && ext_q.size() < 8) ext_q.push_back($urandom);
      step(($urandom % 10) < 6, ($urandom % 10) < 4, ($urandom % 20) == 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule